// File: doc/BRIEF.md
# Shared-Bus General-Purpose Port

An eight-pin general-purpose I/O port whose pads can be handed over to an external data bus. Software sees four byte registers on a register bus with a 16-bit address: a per-pin direction register, an output latch, a read-only view of the synchronised pad levels, and a per-pin pull-up enable. The operating-mode input and the bus-width input decide who owns the pads. In modes 4, 5 and 6 with a 16-bit bus selected, the pads become data-bus pins, and the bus side supplies the drive value and the enable. In every other combination the port is plain I/O under the direction register.

Two synchronous active-low resets and two standby inputs set what each register keeps. A power-on reset or hardware standby empties everything. A manual reset clears the output latch and the pull-up enables but leaves the direction setting in place. Software standby freezes all three registers. The direction register can only be written: a read at its address returns a fixed filler byte with no meaning.

Register reads are combinational. `reg_rdata` is valid in the same cycle that `reg_rd` is high. A write is sampled at the rising edge where `reg_wr` is high and takes effect from that edge.

Top module: `shared_bus_port`

## Requirements
- R1: While `rst_por_n` is low at a rising edge, the direction, output-latch and pull-up registers become 0x00. After release, with mode 7, `pad_oe`, `pad_pu` and the reads of 0xFF0D and 0xFE44 are all 0x00.
- R2: In ordinary I/O ownership, a direction bit of 1 drives `pad_oe` high for that pin and a 0 drives it low. `pad_out` always carries the output latch.
- R3: A write to address 0xFE3D loads the direction register at the rising edge where `reg_wr` is high. Pad enables show the old value before that edge and the new value after it.
- R4: Address 0xFF0D is the output latch (read/write). A read returns the stored byte, not the pad level.
- R5: A read at 0xFFBD returns `pad_in` through a two-flop synchroniser. The old level is still returned after one rising edge, and the new level after two. A write to 0xFFBD changes no register.
- R6: Address 0xFE44 holds the pull-up enables (read/write). In ordinary I/O ownership, `pad_pu` is that register with every output-configured pin forced to 0.
- R7: While `hw_stby` is high at a rising edge, all three registers become 0x00.
- R8: While `rst_man_n` is low, the direction register keeps its value and ignores writes, and the output latch and pull-up enables become 0x00.
- R9: While `sw_stby` is high, all three registers keep their values and writes are ignored.
- R10: With `mode_sel` equal to 4, 5 or 6 and `bus16` high, every bit of `pad_oe` equals `bus_doe`, `pad_out` equals `bus_dout` and `pad_pu` is 0x00, whatever the direction register holds.
- R11: With `mode_sel` equal to 7, or with `bus16` low, or with `mode_sel` in 0 to 3, the port is ordinary I/O under the direction register. `bus_din` always carries `pad_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_man_n | input | 1 | Manual reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby, active high |
| mode_sel | input | 3 | Operating mode (4 to 6 external bus, 7 single-chip) |
| bus16 | input | 1 | 1 selects a 16-bit external data bus |
| reg_addr | input | 16 | Register address (low 16 bits) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (0 when not reading) |
| bus_dout | input | 8 | Drive value from the data-bus side |
| bus_doe | input | 1 | Drive enable from the data-bus side |
| bus_din | output | 8 | Pad levels passed to the data-bus side |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad drive enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The case where two functions land in one cycle is a direction write sampled at the same edge as a manual reset. The manual reset must win, so the old direction stays, while the latch and pull-ups are cleared. The bench asserts `rst_man_n` low and drives a 0x00 direction write in that same cycle. It then judges the outcome at the pads: `pad_oe` must still show the earlier 0xFF, and the latch and pull-up reads must be 0x00. A second overlap, a write attempted during software standby, is judged the same way through the pad enables and the latch readback.

// File: rtl/sbp_pkg.sv
// Package: shared definitions for the shared-bus port.
// Assumes a 3-bit operating-mode code where 4..6 are external-bus modes.
package sbp_pkg;

    localparam int unsigned MODE_W = 3;

    // Register selector produced by the address decoder.
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_DATA = 3'd2,
        SEL_PIN  = 3'd3,
        SEL_PULL = 3'd4
    } reg_sel_e;

    // True for the operating modes that use an external bus.
    function automatic logic is_ext_mode(input logic [MODE_W-1:0] m);
        return (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
    endfunction

endpackage

// File: rtl/sbp_decode.sv
// Module: address decoder.
// Maps a register-bus address onto one of the four port registers.
// Assumes the four addresses are distinct; any other address selects nothing.
module sbp_decode
    import sbp_pkg::*;
#(
    parameter int unsigned       ADDR_W = 16,
    parameter logic [ADDR_W-1:0] A_DIR  = 16'hFE3D,
    parameter logic [ADDR_W-1:0] A_DATA = 16'hFF0D,
    parameter logic [ADDR_W-1:0] A_PIN  = 16'hFFBD,
    parameter logic [ADDR_W-1:0] A_PULL = 16'hFE44
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Compare the address against each register location.
    always_comb begin
        if      (addr == A_DIR)  sel = SEL_DIR;
        else if (addr == A_DATA) sel = SEL_DATA;
        else if (addr == A_PIN)  sel = SEL_PIN;
        else if (addr == A_PULL) sel = SEL_PULL;
        else                     sel = SEL_NONE;
    end

endmodule

// File: rtl/sbp_regs.sv
// Module: port register file.
// Holds the direction, output-latch and pull-up registers with their own
// retention rules. Power-on reset and hardware standby clear all three.
// Manual reset clears the latch and pull-ups but keeps direction.
// Software standby freezes everything. Resets are synchronous, active low.
module sbp_regs
    import sbp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_por_n,
    input  logic         rst_man_n,
    input  logic         hw_stby,
    input  logic         sw_stby,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_q,
    output logic [W-1:0] pull_q
);

    logic wipe_all;
    logic wipe_soft;
    logic wr_ok;

    // Condition terms shared by the three registers.
    always_comb begin
        wipe_all  = !rst_por_n || hw_stby;
        wipe_soft = wipe_all || !rst_man_n;
        wr_ok     = wr && rst_man_n && !sw_stby;
    end

    // Direction register: kept through manual reset and software standby.
    always_ff @(posedge clk) begin
        if (wipe_all)                    dir_q <= '0;
        else if (wr_ok && sel == SEL_DIR) dir_q <= wdata;
    end

    // Output latch: cleared by any reset or hardware standby.
    always_ff @(posedge clk) begin
        if (wipe_soft)                    data_q <= '0;
        else if (wr_ok && sel == SEL_DATA) data_q <= wdata;
    end

    // Pull-up enable register: same retention rules as the output latch.
    always_ff @(posedge clk) begin
        if (wipe_soft)                    pull_q <= '0;
        else if (wr_ok && sel == SEL_PULL) pull_q <= wdata;
    end

    // R8: direction survives a manual reset.
    p_dir_keep_r8: assert property (@(posedge clk) disable iff (!rst_por_n)
        (!rst_man_n && !hw_stby) |=> $stable(dir_q));

    // R8: latch and pull-ups are cleared by a manual reset.
    p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_por_n)
        (!rst_man_n) |=> (data_q == '0 && pull_q == '0));

    // R7: hardware standby empties every register.
    p_hw_clear_r7: assert property (@(posedge clk) disable iff (!rst_por_n)
        hw_stby |=> (dir_q == '0 && data_q == '0 && pull_q == '0));

    // R9: software standby freezes every register.
    p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_por_n)
        (sw_stby && rst_man_n && !hw_stby)
        |=> ($stable(dir_q) && $stable(data_q) && $stable(pull_q)));

    // R5: a write to the pin-state address touches no register.
    p_pin_wr_nop_r5: assert property (@(posedge clk) disable iff (!rst_por_n)
        (wr && sel == SEL_PIN && rst_man_n && !hw_stby)
        |=> ($stable(dir_q) && $stable(data_q) && $stable(pull_q)));

endmodule

// File: rtl/sbp_sync.sv
// Module: multi-flop synchroniser for the pad inputs.
// Assumes the pad levels are asynchronous to clk; the stage count is a
// parameter of at least 1. Stages clear on power-on reset.
module sbp_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_por_n) stg[0] <= '0;
        else            stg[0] <= d;
    end

    // Each further stage re-times the one before it.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_por_n) stg[s] <= '0;
            else            stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sbp_padmux.sv
// Module: pad ownership multiplexer.
// Per pin, it picks between ordinary I/O (direction register and latch) and
// data-bus ownership (bus drive value and one shared enable).
// Assumes bus_own is already decoded from mode and bus width.
module sbp_padmux #(
    parameter int unsigned W = 8
) (
    input  logic         bus_own,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] pull_q,
    input  logic [W-1:0] bus_dout,
    input  logic         bus_doe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        // Select drive, enable and pull-up for one pin.
        always_comb begin
            if (bus_own) begin
                pad_out[i] = bus_dout[i];
                pad_oe[i]  = bus_doe;
                pad_pu[i]  = 1'b0;
            end else begin
                pad_out[i] = data_q[i];
                pad_oe[i]  = dir_q[i];
                pad_pu[i]  = pull_q[i] & ~dir_q[i];
            end
        end
    end

endmodule

// File: rtl/shared_bus_port.sv
// Module: top of the shared-bus general-purpose port.
// Ties together the decoder, register file, input synchroniser and pad mux,
// and forms the combinational read path. Assumes one register access per
// cycle; a read at the direction address returns a fixed filler byte.
module shared_bus_port
    import sbp_pkg::*;
#(
    parameter int unsigned       W          = 8,
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       SYNC_STG   = 2,
    parameter logic [ADDR_W-1:0] A_DIR      = 16'hFE3D,
    parameter logic [ADDR_W-1:0] A_DATA     = 16'hFF0D,
    parameter logic [ADDR_W-1:0] A_PIN      = 16'hFFBD,
    parameter logic [ADDR_W-1:0] A_PULL     = 16'hFE44,
    parameter logic [W-1:0]      DIR_FILLER = '1
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_man_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [2:0]        mode_sel,
    input  logic              bus16,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      bus_dout,
    input  logic              bus_doe,
    output logic [W-1:0]      bus_din,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu
);

    reg_sel_e     sel;
    logic [W-1:0] dir_q;
    logic [W-1:0] data_q;
    logic [W-1:0] pull_q;
    logic [W-1:0] pin_sync;
    logic         bus_own;

    sbp_decode #(
        .ADDR_W(ADDR_W), .A_DIR(A_DIR), .A_DATA(A_DATA),
        .A_PIN(A_PIN), .A_PULL(A_PULL)
    ) u_dec (
        .addr(reg_addr),
        .sel (sel)
    );

    sbp_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_por_n(rst_por_n),
        .rst_man_n(rst_man_n),
        .hw_stby  (hw_stby),
        .sw_stby  (sw_stby),
        .wr       (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .pull_q   (pull_q)
    );

    sbp_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_por_n(rst_por_n),
        .d        (pad_in),
        .q        (pin_sync)
    );

    // Bus ownership: external-bus mode with the wide data bus.
    always_comb bus_own = is_ext_mode(mode_sel) && bus16;

    sbp_padmux #(.W(W)) u_mux (
        .bus_own (bus_own),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .pull_q  (pull_q),
        .bus_dout(bus_dout),
        .bus_doe (bus_doe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // Pad levels go straight to the data-bus side.
    assign bus_din = pad_in;

    // Read path: the selected register while reading, zero otherwise.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (sel)
                SEL_DIR:  reg_rdata = DIR_FILLER;
                SEL_DATA: reg_rdata = data_q;
                SEL_PIN:  reg_rdata = pin_sync;
                SEL_PULL: reg_rdata = pull_q;
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R6: a pull-up is never on for a pin that is being driven.
    p_pull_excl_r6: assert property (@(posedge clk) disable iff (!rst_por_n)
        (pad_pu & pad_oe) == '0);

    // R10: in wide-bus ownership the pads follow the bus side, with no pull-ups.
    p_bus_take_r10: assert property (@(posedge clk) disable iff (!rst_por_n)
        (is_ext_mode(mode_sel) && bus16)
        |-> (pad_out == bus_dout && pad_pu == '0));

endmodule

// File: tb/sim_shared_bus_port.sv
`timescale 1ns/1ps
module sim_shared_bus_port;

    localparam logic [15:0] A_DIR  = 16'hFE3D;
    localparam logic [15:0] A_DATA = 16'hFF0D;
    localparam logic [15:0] A_PIN  = 16'hFFBD;
    localparam logic [15:0] A_PULL = 16'hFE44;

    typedef struct packed {
        logic [2:0] mode;
        logic       b16;
        logic [7:0] dir;
        logic [7:0] dat;
        logic [7:0] pul;
        logic       doe;
        logic [7:0] bdo;
        logic [7:0] e_oe;
        logic [7:0] e_out;
        logic [7:0] e_pu;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd7, 1'b0, 8'hF0, 8'hA5, 8'hFF, 1'b0, 8'h00, 8'hF0, 8'hA5, 8'h0F},
        '{3'd7, 1'b1, 8'h0F, 8'h3C, 8'h33, 1'b1, 8'hFF, 8'h0F, 8'h3C, 8'h30},
        '{3'd4, 1'b0, 8'h81, 8'h7E, 8'hFF, 1'b1, 8'h55, 8'h81, 8'h7E, 8'h7E},
        '{3'd5, 1'b1, 8'hFF, 8'h12, 8'hFF, 1'b1, 8'hC3, 8'hFF, 8'hC3, 8'h00},
        '{3'd6, 1'b1, 8'h00, 8'h99, 8'hAA, 1'b0, 8'h66, 8'h00, 8'h66, 8'h00},
        '{3'd6, 1'b0, 8'h00, 8'h99, 8'hAA, 1'b0, 8'h66, 8'h00, 8'h99, 8'hAA},
        '{3'd2, 1'b1, 8'h3C, 8'hFF, 8'hC3, 1'b1, 8'h00, 8'h3C, 8'hFF, 8'hC3}
    };

    logic        clk = 1'b0;
    logic        rst_por_n = 1'b0;
    logic        rst_man_n = 1'b1;
    logic        hw_stby = 1'b0;
    logic        sw_stby = 1'b0;
    logic [2:0]  mode_sel = 3'd7;
    logic        bus16 = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  bus_dout = '0;
    logic        bus_doe = 1'b0;
    logic [7:0]  bus_din;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shared_bus_port u0 (
        .clk(clk), .rst_por_n(rst_por_n), .rst_man_n(rst_man_n),
        .hw_stby(hw_stby), .sw_stby(sw_stby), .mode_sel(mode_sel),
        .bus16(bus16), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_por_n = 1'b1;

        // R1: reset state
        rd(A_DATA, v); chk("R1 latch", v, 8'h00);
        rd(A_PULL, v); chk("R1 pull", v, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);

        // Vector table: R2 R4 R6 R10 R11
        for (int i = 0; i < NV; i++) begin
            mode_sel = VECS[i].mode; bus16 = VECS[i].b16;
            bus_doe = VECS[i].doe; bus_dout = VECS[i].bdo;
            pad_in = 8'(i * 37 + 5);
            wr(A_DIR, VECS[i].dir);
            wr(A_DATA, VECS[i].dat);
            wr(A_PULL, VECS[i].pul);
            #1;
            chk("R2/R10 oe", pad_oe, VECS[i].e_oe);
            chk("R2/R10 out", pad_out, VECS[i].e_out);
            chk("R6/R10 pu", pad_pu, VECS[i].e_pu);
            chk("R11 bus_din", bus_din, 8'(i * 37 + 5));
            rd(A_DATA, v); chk("R4 latch readback", v, VECS[i].dat);
            rd(A_PULL, v); chk("R6 pull readback", v, VECS[i].pul);
        end

        mode_sel = 3'd7; bus16 = 1'b0;
        wr(A_DIR, 8'h00);

        // R3: direction write takes effect at the strobe edge
        @(negedge clk);
        reg_addr = A_DIR; reg_wdata = 8'hFF; reg_wr = 1'b1;
        #1 chk("R3 before edge", pad_oe, 8'h00);
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk("R3 after edge", pad_oe, 8'hFF);

        // R5: two-flop latency of the pin-state read
        @(negedge clk);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h6B; reg_addr = A_PIN; reg_rd = 1'b1;
        #1 chk("R5 no edge", reg_rdata, 8'h00);
        @(negedge clk); #1 chk("R5 one edge", reg_rdata, 8'h00);
        @(negedge clk); #1 chk("R5 two edges", reg_rdata, 8'h6B);
        reg_rd = 1'b0;
        rd(A_DATA, v); chk("R4 latch not pad", v, VECS[NV-1].dat);

        // R5: write to pin-state address is ignored
        wr(A_DIR, 8'h0F); wr(A_DATA, 8'h33); wr(A_PULL, 8'hF0);
        wr(A_PIN, 8'hAA);
        #1 chk("R5 wr dir kept", pad_oe, 8'h0F);
        rd(A_DATA, v); chk("R5 wr latch kept", v, 8'h33);
        rd(A_PULL, v); chk("R5 wr pull kept", v, 8'hF0);

        // R8: manual reset in the same cycle as a direction write
        wr(A_DIR, 8'hFF); wr(A_DATA, 8'h55); wr(A_PULL, 8'h0F);
        @(negedge clk);
        rst_man_n = 1'b0; reg_addr = A_DIR; reg_wdata = 8'h00; reg_wr = 1'b1;
        @(negedge clk);
        rst_man_n = 1'b1; reg_wr = 1'b0;
        #1 chk("R8 dir kept", pad_oe, 8'hFF);
        rd(A_DATA, v); chk("R8 latch cleared", v, 8'h00);
        rd(A_PULL, v); chk("R8 pull cleared", v, 8'h00);

        // R9: software standby freezes registers and drops writes
        wr(A_DATA, 8'h5A); wr(A_PULL, 8'h00);
        @(negedge clk); sw_stby = 1'b1;
        wr(A_DIR, 8'h00); wr(A_DATA, 8'hA5); wr(A_PULL, 8'hFF);
        #1 chk("R9 dir frozen", pad_oe, 8'hFF);
        rd(A_DATA, v); chk("R9 latch frozen", v, 8'h5A);
        rd(A_PULL, v); chk("R9 pull frozen", v, 8'h00);
        @(negedge clk); sw_stby = 1'b0;

        // R7: hardware standby clears everything
        wr(A_PULL, 8'h3C);
        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk); hw_stby = 1'b0;
        #1 chk("R7 dir cleared", pad_oe, 8'h00);
        rd(A_DATA, v); chk("R7 latch cleared", v, 8'h00);
        rd(A_PULL, v); chk("R7 pull cleared", v, 8'h00);

        // R10: direction ignored under wide-bus ownership
        wr(A_DIR, 8'hFF); wr(A_PULL, 8'hFF);
        mode_sel = 3'd4; bus16 = 1'b1; bus_doe = 1'b0; bus_dout = 8'h9C;
        #1 chk("R10 oe from bus", pad_oe, 8'h00);
        chk("R10 out from bus", pad_out, 8'h9C);
        chk("R10 pu off", pad_pu, 8'h00);
        // R11: mode 7 ignores the bus width
        mode_sel = 3'd7;
        #1 chk("R11 mode7 oe", pad_oe, 8'hFF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule